// File: doc/BRIEF.md
# Multiplexed Bus Read Cycle Sequencer

This block is the processor-side master for read cycles on a bus where the low address bits and the data word share one set of lines. One accepted request becomes one read cycle built from clock states T1, T2, T3, any number of wait states Tw, and T4. In T1 the block drives the address onto the shared lines and pulses the address latch strobe, so that an external latch can capture the address on its falling edge. From T2 onward the block releases the shared lines and asserts the read strobe, which lets the addressed device drive data.

The cycle stays open until the device raises its ready input. The block captures the shared lines in the clock where ready is seen high, closes the strobes in T4, and then presents the captured word with a one-clock done pulse. It also drives the memory-or-I/O qualifier, the active-low high-byte enable, and the direction and enable controls for an external bus transceiver. The shared bus appears as three separate signals: an output value, an output enable and an input value. Driving the enable low stands for high impedance.

Top module: `mux_bus_reader`

## Requirements
- R1: After reset and while idle, the block drives ale_o=0, ad_oe_o=0, rd_n_o=1, den_n_o=1, dtr_n_o=1, bhe_n_o=1 and done_o=0.
- R2: In T1, which is the first clock after a request is accepted, the block drives ale_o=1 and ad_oe_o=1. It drives ad_o with request address bits [15:1] in bits [15:1] and the derived A0 in bit 0, and a_hi_o with address bits [19:16].
- R3: The byte select maps as follows. sel_i=2'b01 is the low byte: A0=0 and bhe_n_o=1. 2'b10 is the high byte: A0=1 and bhe_n_o=0. 2'b11 or 2'b00 is the whole word: A0=0 and bhe_n_o=0. bhe_n_o holds its value from T1 through T4.
- R4: In T2, ale_o=0, ad_oe_o=0, rd_n_o=0 and den_n_o=0.
- R5: ready_i is first sampled at the end of T3. Each low sample adds one wait state, so rd_n_o stays low for exactly 2 + W clocks when W low samples come before the high one.
- R6: The word on ad_i in the clock where ready_i is sampled high is the word returned. Values on ad_i in earlier wait clocks are discarded.
- R7: In T4, rd_n_o=1, den_n_o=1 and ad_oe_o=0, while dtr_n_o is still 0.
- R8: In the clock after T4, done_o=1 for exactly one clock and data_o equals the captured word. dtr_n_o returns to 1 in that clock.
- R9: mio_o equals the request's mio_i flag (1 = memory) and stays constant from T1 through T4.
- R10: A request raised while a cycle is in progress is ignored. No new T1 follows the cycle's done clock.
- R11: dtr_n_o is 0 in every clock from T1 through T4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request, taken only when idle |
| addr_i | input | 20 | Request address |
| sel_i | input | 2 | Byte select: 01 low, 10 high, 11 or 00 word |
| mio_i | input | 1 | 1 memory, 0 I/O |
| ready_i | input | 1 | Device ready, sampled from the end of T3 |
| ad_i | input | 16 | Shared-line input value |
| ad_o | output | 16 | Shared-line output value (address in T1) |
| ad_oe_o | output | 1 | Shared-line output enable; 0 means high impedance |
| a_hi_o | output | 4 | Upper address bits for the cycle |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| mio_o | output | 1 | Memory-or-I/O qualifier |
| bhe_n_o | output | 1 | High-byte enable, active low |
| dtr_n_o | output | 1 | Transceiver direction, low for receive |
| den_n_o | output | 1 | Transceiver enable, active low |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | One-clock completion pulse |
| data_o | output | 16 | Captured read word |

## Verification
The sweep covers every byte-select code, both mio values and zero to three low ready samples before the high one, with a distinct address and data word for each cycle. Varying the wait count separates a sequencer that samples ready at the right time from one that samples too early or ignores it. The strobe width is measured against 2 + W. During waits the bench drives the complement of the data word, so a capture taken from the wrong clock shows up as an inverted word. The byte-select codes separate the A0 and high-byte-enable decoding for each lane, and a request raised mid-cycle shows whether the idle-only acceptance holds.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_T1   = 3'd1,
        S_T2   = 3'd2,
        S_T3   = 3'd3,
        S_TW   = 3'd4,
        S_T4   = 3'd5
    } tstate_e;

    localparam logic [1:0] SEL_LO   = 2'b01;
    localparam logic [1:0] SEL_HI   = 2'b10;
    localparam logic [1:0] SEL_WORD = 2'b11;
endpackage

// File: rtl/mbr_lane_decode.sv
module mbr_lane_decode (
    input  logic [1:0] sel_i,
    output logic       a0_o,
    output logic       bhe_n_o
);
    import mbr_pkg::*;

    logic want_hi;
    logic want_lo;

    always_comb begin
        want_hi = (sel_i == SEL_HI) || (sel_i == SEL_WORD) || (sel_i == 2'b00);
        want_lo = (sel_i == SEL_LO) || (sel_i == SEL_WORD) || (sel_i == 2'b00);
        a0_o    = want_hi && !want_lo;
        bhe_n_o = !want_hi;
    end
endmodule

// File: rtl/mbr_seq_fsm.sv
module mbr_seq_fsm #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_i,
    input  logic [ADDR_W-1:1]        addr_i,
    input  logic                     a0_i,
    input  logic                     bhe_n_i,
    input  logic                     mio_i,
    input  logic                     ready_i,
    input  logic [DATA_W-1:0]        ad_i,
    output logic [DATA_W-1:0]        ad_o,
    output logic                     ad_oe_o,
    output logic [ADDR_W-DATA_W-1:0] a_hi_o,
    output logic                     ale_o,
    output logic                     rd_n_o,
    output logic                     mio_o,
    output logic                     bhe_n_o,
    output logic                     dtr_n_o,
    output logic                     den_n_o,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [DATA_W-1:0]        data_o
);
    import mbr_pkg::*;

    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        tstate_e             st;
        logic [ADDR_W-1:1]   addr;
        logic                a0;
        logic                bhe_n;
        logic                mio;
        logic [DATA_W-1:0]   data;
        logic                done;
    } seq_t;

    seq_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (req_i) begin
                    r_d.st    = S_T1;
                    r_d.addr  = addr_i;
                    r_d.a0    = a0_i;
                    r_d.bhe_n = bhe_n_i;
                    r_d.mio   = mio_i;
                end
            end
            S_T1: r_d.st = S_T2;
            S_T2: r_d.st = S_T3;
            S_T3, S_TW: begin
                if (ready_i) begin
                    r_d.data = ad_i;
                    r_d.st   = S_T4;
                end else begin
                    r_d.st   = S_TW;
                end
            end
            S_T4: begin
                r_d.st   = S_IDLE;
                r_d.done = 1'b1;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, addr: '0, a0: 1'b0, bhe_n: 1'b1,
                     mio: 1'b0, data: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    logic strobe_phase;

    always_comb begin
        strobe_phase = (r_q.st == S_T2) || (r_q.st == S_T3) || (r_q.st == S_TW);
        busy_o  = (r_q.st != S_IDLE);
        ale_o   = (r_q.st == S_T1);
        ad_oe_o = (r_q.st == S_T1);
        ad_o    = ale_o ? {r_q.addr[DATA_W-1:1], r_q.a0} : '0;
        a_hi_o  = busy_o ? r_q.addr[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
        rd_n_o  = !strobe_phase;
        den_n_o = !strobe_phase;
        dtr_n_o = !busy_o;
        bhe_n_o = busy_o ? r_q.bhe_n : 1'b1;
        mio_o   = r_q.mio;
        done_o  = r_q.done;
        data_o  = r_q.data;
    end

    // R4
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> !ad_oe_o);

    // R2
    ale_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> (!ale_o && !rd_n_o));

    // R5
    wait_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n_o && !ready_i && r_q.st != S_T2) |=> !rd_n_o);

    // R7
    den_inside_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !den_n_o |-> !rd_n_o);

    // R8
    done_after_t4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(rd_n_o) && !$past(dtr_n_o) && dtr_n_o));

    // R9
    mio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtr_n_o && !ale_o) |-> $stable(mio_o));

    // R3
    bhe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dtr_n_o && !ale_o) |-> $stable(bhe_n_o));
endmodule

// File: rtl/mux_bus_reader.sv
module mux_bus_reader #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [1:0]               sel_i,
    input  logic                     mio_i,
    input  logic                     ready_i,
    input  logic [DATA_W-1:0]        ad_i,
    output logic [DATA_W-1:0]        ad_o,
    output logic                     ad_oe_o,
    output logic [ADDR_W-DATA_W-1:0] a_hi_o,
    output logic                     ale_o,
    output logic                     rd_n_o,
    output logic                     mio_o,
    output logic                     bhe_n_o,
    output logic                     dtr_n_o,
    output logic                     den_n_o,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [DATA_W-1:0]        data_o
);
    logic lane_a0;
    logic lane_bhe_n;

    mbr_lane_decode i_lane (
        .sel_i   (sel_i),
        .a0_o    (lane_a0),
        .bhe_n_o (lane_bhe_n)
    );

    mbr_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .addr_i  (addr_i[ADDR_W-1:1]),
        .a0_i    (lane_a0),
        .bhe_n_i (lane_bhe_n),
        .mio_i   (mio_i),
        .ready_i (ready_i),
        .ad_i    (ad_i),
        .ad_o    (ad_o),
        .ad_oe_o (ad_oe_o),
        .a_hi_o  (a_hi_o),
        .ale_o   (ale_o),
        .rd_n_o  (rd_n_o),
        .mio_o   (mio_o),
        .bhe_n_o (bhe_n_o),
        .dtr_n_o (dtr_n_o),
        .den_n_o (den_n_o),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .data_o  (data_o)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (rd_n_o && den_n_o && dtr_n_o && !ad_oe_o && !ale_o));
endmodule

// File: tb/test_mux_bus_reader.sv
module test_mux_bus_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [19:0] addr_i = '0;
    logic [1:0]  sel_i = '0;
    logic        mio_i = 1'b0;
    logic        ready_i = 1'b0;
    logic [15:0] ad_i = '0;
    logic [15:0] ad_o;
    logic        ad_oe_o;
    logic [3:0]  a_hi_o;
    logic        ale_o, rd_n_o, mio_o, bhe_n_o, dtr_n_o, den_n_o, busy_o, done_o;
    logic [15:0] data_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mux_bus_reader i_mux_bus_reader (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i), .sel_i(sel_i),
        .mio_i(mio_i), .ready_i(ready_i), .ad_i(ad_i), .ad_o(ad_o),
        .ad_oe_o(ad_oe_o), .a_hi_o(a_hi_o), .ale_o(ale_o), .rd_n_o(rd_n_o),
        .mio_o(mio_o), .bhe_n_o(bhe_n_o), .dtr_n_o(dtr_n_o), .den_n_o(den_n_o),
        .busy_o(busy_o), .done_o(done_o), .data_o(data_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_read(input logic [19:0] addr, input logic [1:0] sel,
                            input logic mio, input int waits,
                            input logic [15:0] word, input bit probe);
        logic exp_a0;
        logic exp_bhe_n;
        int   rd_low;
        // R3 encoding from the requirement
        exp_a0    = (sel == 2'b10);
        exp_bhe_n = (sel == 2'b01);
        rd_low    = 0;

        @(negedge clk);
        req_i = 1'b1; addr_i = addr; sel_i = sel; mio_i = mio;
        @(negedge clk);
        req_i = 1'b0; addr_i = ~addr; sel_i = ~sel; mio_i = ~mio;
        // T1
        chk(ale_o && ad_oe_o, "R2 ale/oe in T1", {ale_o, ad_oe_o}, 2'b11);
        chk(ad_o == {addr[15:1], exp_a0}, "R2/R3 address and A0",
            ad_o, {addr[15:1], exp_a0});
        chk(a_hi_o == addr[19:16], "R2 upper address", a_hi_o, addr[19:16]);
        chk(bhe_n_o == exp_bhe_n, "R3 bhe_n", bhe_n_o, exp_bhe_n);
        chk(mio_o == mio, "R9 mio in T1", mio_o, mio);
        chk(dtr_n_o == 1'b0, "R11 dtr_n in T1", dtr_n_o, 0);
        @(negedge clk);
        // T2
        chk(!ale_o && !ad_oe_o && !rd_n_o && !den_n_o, "R4 T2 strobes",
            {ale_o, ad_oe_o, rd_n_o, den_n_o}, 4'b0000);
        if (!rd_n_o) rd_low++;
        if (probe) begin
            req_i = 1'b1; addr_i = 20'h0FFFF;
        end
        @(negedge clk);
        req_i = 1'b0;
        // T3 and wait states
        for (int w = 0; w <= waits; w++) begin
            ready_i = (w == waits);
            ad_i    = (w == waits) ? word : ~word;
            chk(mio_o == mio && bhe_n_o == exp_bhe_n, "R9/R3 held in T3/Tw",
                {mio_o, bhe_n_o}, {mio, exp_bhe_n});
            chk(dtr_n_o == 1'b0, "R11 dtr_n in T3/Tw", dtr_n_o, 0);
            if (!rd_n_o) rd_low++;
            @(negedge clk);
        end
        ready_i = 1'b0; ad_i = 16'h0BAD;
        // T4
        chk(rd_low == 2 + waits, "R5 strobe width", rd_low, 2 + waits);
        chk(rd_n_o && den_n_o && !ad_oe_o, "R7 T4 strobes",
            {rd_n_o, den_n_o, ad_oe_o}, 3'b110);
        chk(dtr_n_o == 1'b0 && mio_o == mio, "R11/R9 T4", {dtr_n_o, mio_o}, {1'b0, mio});
        chk(done_o == 1'b0, "R8 no early done", done_o, 0);
        @(negedge clk);
        chk(done_o == 1'b1 && dtr_n_o == 1'b1, "R8 done pulse", {done_o, dtr_n_o}, 2'b11);
        chk(data_o == word, "R6 captured word", data_o, word);
        @(negedge clk);
        chk(done_o == 1'b0, "R8 done one clock", done_o, 0);
        chk(!ale_o && !busy_o, probe ? "R10 busy request ignored" : "R1 back idle",
            {ale_o, busy_o}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!ale_o && !ad_oe_o && rd_n_o && den_n_o && dtr_n_o && bhe_n_o && !done_o,
            "R1 reset outputs",
            {ale_o, ad_oe_o, rd_n_o, den_n_o, dtr_n_o, bhe_n_o, done_o}, 7'b0011110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && rd_n_o, "R1 idle after reset", {busy_o, rd_n_o}, 2'b01);
        for (int s = 0; s < 4; s++)
            for (int m = 0; m < 2; m++)
                for (int w = 0; w < 4; w++) begin
                    int idx;
                    logic [19:0] a;
                    logic [15:0] d;
                    idx = s * 8 + m * 4 + w;
                    a = 20'(idx * 20'h1357B + 20'h2468D);
                    d = 16'(idx * 16'h3C71 + 16'h9A5);
                    run_read(a, 2'(s), m[0], w, d, (idx % 5) == 2);
                end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule